// File: doc/BRIEF.md
# Four-Lane Pixel Serializer

This block turns a 28-bit parallel pixel word into four serial data lanes and one forwarded-clock lane for a display link. A word is sampled once per pixel-clock period, on the rising or the falling pixel-clock edge depending on a select input. The sampled word then moves into a staging register on a slot-start strobe. At the next strobe it is split into four 7-bit slices, and each slice is shifted out on its own lane, one bit per cycle of a bit clock that runs at seven times the pixel rate.

The bit clock and the strobe come from outside the block. An external frequency multiplier makes the bit clock, and the strobe marks the first bit cycle of every 7-cycle slot. A fifth lane repeats a fixed 7-bit pattern each slot, which gives the receiver one rising edge per pixel.

An active-low shutdown input clears every register in the block at once. While shutdown is low, an output-enable flag is low and all lane outputs are held low.

Top module: `pixel_lane_serializer`

## Requirements
- R1: All 28 bits of `pix_data` are sampled together as one word, once per pixel-clock period.
- R2: When `edge_rise` is 1 the word is sampled on the rising edge of `pix_clk`. When it is 0 the word is sampled on the falling edge.
- R3: Lane k (`lane_data[k]`, k = 0..3) carries word bits [7k+6:7k], highest bit first, one bit per `bit_clk` cycle. The first bit of a slot appears in the cycle after the `bit_clk` edge that sees `slot_start` high.
- R4: `lane_clk` sends the bits 1,1,0,0,0,1,1 in that order during every slot. It starts at the first slot start after shutdown is released.
- R5: While `shutdown_n` is 0, all registers are cleared asynchronously, `lane_oe` is 0, and `lane_data` and `lane_clk` are 0.
- R6: A word sampled before slot-start edge N is moved into the staging register at edge N. It is shifted out in the slot that begins at edge N+1.
- R7: After `shutdown_n` rises, `lane_oe` goes high on the second `bit_clk` rising edge. The data lanes send only zeros, and no word from before the shutdown, until a word sampled after the release reaches them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bit_clk | input | 1 | Bit clock at seven times the pixel rate, phase-aligned to `pix_clk` |
| pix_clk | input | 1 | Pixel clock |
| shutdown_n | input | 1 | Active-low shutdown and clear |
| edge_rise | input | 1 | Sampling-edge select: 1 = rising, 0 = falling |
| slot_start | input | 1 | One-`bit_clk`-cycle strobe that starts each 7-bit slot |
| pix_data | input | 28 | Parallel pixel word |
| lane_data | output | 4 | Serial data lanes |
| lane_clk | output | 1 | Forwarded-clock lane |
| lane_oe | output | 1 | Output enable, low during shutdown |

## Verification
The assertions assume three things about the inputs:
- `slot_start` pulses for exactly one `bit_clk` cycle in every seven.
- The selected `pix_clk` edge settles before the `bit_clk` edge that loads the staging register.
- No word is needed from the first two pixel periods after a release.

The stimulus meets these assumptions by building both clocks and the strobe from one timeline, with 14 half-bit steps per pixel period. The pixel clock rises 3 ns before the strobed `bit_clk` edge. The data changes twice per period: once between the rising and falling pixel edges, and once after the falling edge. This means the two `edge_rise` settings pick different words. Zero words are driven in the two periods after each release.

// File: rtl/ser_pkg.sv
`timescale 1ns/1ps
package ser_pkg;

  localparam int unsigned DEF_LANES = 4;
  localparam int unsigned DEF_SLOT  = 7;
  localparam logic [6:0]  DEF_CLK_PAT = 7'b1100011;

  typedef enum logic {
    EDGE_FALL = 1'b0,
    EDGE_RISE = 1'b1
  } edge_sel_e;

endpackage

// File: rtl/rst_sync.sv
`timescale 1ns/1ps
// Reset that asserts at once and releases on the STAGES-th clock edge.
module rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sync_q <= '0;
    else         sync_q <= sync_d;
  end

  assign rst_n = sync_q[STAGES-1];

endmodule

// File: rtl/pix_capture.sv
`timescale 1ns/1ps
// Samples the pixel word on both pixel-clock edges; the select picks one.
module pix_capture
  import ser_pkg::*;
#(
  parameter int unsigned WIDTH = 28
) (
  input  logic             pix_clk,
  input  logic             rst_n,
  input  logic             rise_sel,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);

  logic [WIDTH-1:0] rise_q, rise_d;
  logic [WIDTH-1:0] fall_q, fall_d;

  always_comb begin
    rise_d = din;
    fall_d = din;
  end

  always_ff @(posedge pix_clk or negedge rst_n) begin
    if (!rst_n) rise_q <= '0;
    else        rise_q <= rise_d;
  end

  always_ff @(negedge pix_clk or negedge rst_n) begin
    if (!rst_n) fall_q <= '0;
    else        fall_q <= fall_d;
  end

  assign dout = (rise_sel == EDGE_RISE) ? rise_q : fall_q;

endmodule

// File: rtl/slot_shifter.sv
`timescale 1ns/1ps
// One lane: parallel load on strobe, MSB-first shift otherwise.
module slot_shifter #(
  parameter int unsigned W = 7
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] din,
  output logic         sout
);

  logic [W-1:0] sh_q, sh_d;

  always_comb begin
    if (load) sh_d = din;
    else      sh_d = {sh_q[W-2:0], 1'b0};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= sh_d;
  end

  assign sout = sh_q[W-1];

  // R3: a strobe puts the whole slice into the lane register
  assert_load_R3: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (sh_q == $past(din)))
    else $error("lane register missed its slot load");

  // R3: without a strobe the slice advances one place toward the output
  assert_shift_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> (sh_q == {$past(sh_q[W-2:0]), 1'b0}))
    else $error("lane register did not advance by one bit");

endmodule

// File: rtl/pixel_lane_serializer.sv
`timescale 1ns/1ps
module pixel_lane_serializer
  import ser_pkg::*;
#(
  parameter int unsigned LANES   = DEF_LANES,
  parameter int unsigned SLOT_W  = DEF_SLOT,
  parameter logic [SLOT_W-1:0] CLK_PAT = DEF_CLK_PAT,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic                       bit_clk,
  input  logic                       pix_clk,
  input  logic                       shutdown_n,
  input  logic                       edge_rise,
  input  logic                       slot_start,
  input  logic [LANES*SLOT_W-1:0]    pix_data,
  output logic [LANES-1:0]           lane_data,
  output logic                       lane_clk,
  output logic                       lane_oe
);

  localparam int unsigned DATA_W = LANES * SLOT_W;

  logic              rst_bit_n;
  logic              rst_pix_n;
  logic [DATA_W-1:0] cap_word;
  logic [DATA_W-1:0] hold_q, hold_d;
  logic [LANES-1:0]  lane_raw;
  logic              clk_raw;

  rst_sync #(.STAGES(SYNC_STAGES)) u_rst_bit (
    .clk    (bit_clk),
    .arst_n (shutdown_n),
    .rst_n  (rst_bit_n)
  );

  rst_sync #(.STAGES(SYNC_STAGES)) u_rst_pix (
    .clk    (pix_clk),
    .arst_n (shutdown_n),
    .rst_n  (rst_pix_n)
  );

  pix_capture #(.WIDTH(DATA_W)) u_capture (
    .pix_clk  (pix_clk),
    .rst_n    (rst_pix_n),
    .rise_sel (edge_rise),
    .din      (pix_data),
    .dout     (cap_word)
  );

  // Staging register in the bit-clock domain, enabled by the slot strobe
  always_comb begin
    if (slot_start) hold_d = cap_word;
    else            hold_d = hold_q;
  end

  always_ff @(posedge bit_clk or negedge rst_bit_n) begin
    if (!rst_bit_n) hold_q <= '0;
    else            hold_q <= hold_d;
  end

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    slot_shifter #(.W(SLOT_W)) u_shift (
      .clk   (bit_clk),
      .rst_n (rst_bit_n),
      .load  (slot_start),
      .din   (hold_q[k*SLOT_W +: SLOT_W]),
      .sout  (lane_raw[k])
    );
  end

  slot_shifter #(.W(SLOT_W)) u_clk_lane (
    .clk   (bit_clk),
    .rst_n (rst_bit_n),
    .load  (slot_start),
    .din   (CLK_PAT),
    .sout  (clk_raw)
  );

  assign lane_oe   = rst_bit_n;
  assign lane_data = lane_raw & {LANES{lane_oe}};
  assign lane_clk  = clk_raw & lane_oe;

  // R6: the staging register takes the sampled word at each slot start
  assert_stage_R6: assert property (@(posedge bit_clk) disable iff (!rst_bit_n)
    slot_start |=> (hold_q == $past(cap_word)))
    else $error("staging register missed the sampled word");

  // R4: the forwarded clock opens every slot with its leading pattern bit
  assert_clk_lead_R4: assert property (@(posedge bit_clk) disable iff (!rst_bit_n)
    slot_start |=> (lane_clk == CLK_PAT[SLOT_W-1]))
    else $error("forwarded clock lane wrong at slot start");

endmodule

// File: tb/tb_pixel_lane_serializer.sv
`timescale 1ns/1ps
module tb_pixel_lane_serializer;

  localparam int CLK_PERIOD = 10;
  localparam int EDGE_GAP   = 2;
  localparam logic [6:0] PAT = 7'b1100011;

  logic        bit_clk, pix_clk, shutdown_n, edge_rise, slot_start;
  logic [27:0] pix_data;
  logic [3:0]  lane_data;
  logic        lane_clk, lane_oe;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 0;

  logic [27:0] cur_w = '0;
  logic [27:0] nxt_w = '0;
  bit          clk_cur = 0;

  pixel_lane_serializer dut (
    .bit_clk    (bit_clk),
    .pix_clk    (pix_clk),
    .shutdown_n (shutdown_n),
    .edge_rise  (edge_rise),
    .slot_start (slot_start),
    .pix_data   (pix_data),
    .lane_data  (lane_data),
    .lane_clk   (lane_clk),
    .lane_oe    (lane_oe)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  // One pixel period = 14 half-bit steps. The pixel clock rises at step 0
  // and falls at step 7. The strobe covers the bit-clock rise of step 0.
  // Word w is driven at step 4 and word x at step 10.
  task automatic run_period(input logic [27:0] w, input logic [27:0] x,
                            input logic sel, input logic sd, input bit chk,
                            input string tag);
    logic [27:0] eff;
    for (int h = 0; h < 14; h++) begin
      #(EDGE_GAP);
      if (h == 0)  pix_clk = 1'b1;
      if (h == 7)  pix_clk = 1'b0;
      if (h == 1)  slot_start = 1'b0;
      if (h == 13) slot_start = 1'b1;
      if (h == 4) begin
        pix_data = w;
        edge_rise = sel;
        shutdown_n = sd;
      end
      if (h == 10) pix_data = x;
      if (chk && (h % 2 == 1)) begin
        int b;
        logic [3:0] el;
        b = (h - 1) / 2;
        for (int k = 0; k < 4; k++) el[k] = cur_w[7*k + 6 - b];
        check({tag, " data lanes"}, 32'(lane_data), 32'(el));
        check("R4 clock lane", 32'(lane_clk), clk_cur ? 32'(PAT[6-b]) : 32'd0);
        check("R5 R7 output enable", 32'(lane_oe), 32'(sd));
      end
      #(CLK_PERIOD/2 - EDGE_GAP);
      bit_clk = ~bit_clk;
    end
    eff = sel ? x : w;
    if (!sd) begin
      cur_w = '0; nxt_w = '0; clk_cur = 0;
    end else begin
      cur_w = nxt_w; nxt_w = eff; clk_cur = 1;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    bit_clk = 0; pix_clk = 0; slot_start = 0; edge_rise = 1;
    pix_data = '0; shutdown_n = 1'b1;
    #1 shutdown_n = 1'b0;

    // R5: reset state while shut down, with busy input words
    for (int i = 0; i < 3; i++)
      run_period(28'hABCDEF1 + 28'(i), 28'h7654321, 1'b1, 1'b0, 1, "R5");
    run_period('0, '0, 1'b1, 1'b1, 0, "release");
    // R7: zeros after release, forwarded clock running
    run_period('0, '0, 1'b0, 1'b1, 1, "R7");
    run_period('0, '0, 1'b1, 1'b1, 1, "R7");

    // R1 R2 R3 R6: walking ones, edge select alternating
    for (int i = 0; i < 28; i++)
      run_period(~(28'd1 << i), 28'd1 << i, 1'(i % 2), 1'b1, 1, "R1 R2 R3 R6");

    // R1 R2 R3 R6: arithmetic word sequence
    for (int i = 0; i < 16; i++) begin
      logic [27:0] a;
      a = 28'(i * 32'h00F1E2D3 + 32'h0123457);
      run_period(a, ~a ^ 28'(i << 3), 1'(i % 3 == 0), 1'b1, 1, "R1 R2 R3 R6");
    end

    // R5: shutdown in mid-stream, then R7 restart without stale data
    run_period(28'h5555555, 28'hAAAAAAA, 1'b1, 1'b0, 0, "R5 entry");
    run_period(28'h1234567, 28'hFEDCBA9, 1'b0, 1'b0, 1, "R5");
    run_period(28'h0FF00FF, 28'hF00FF00, 1'b1, 1'b0, 1, "R5");
    run_period('0, '0, 1'b0, 1'b1, 0, "release");
    run_period('0, '0, 1'b0, 1'b1, 1, "R7");
    run_period('0, '0, 1'b1, 1'b1, 1, "R7");
    for (int i = 0; i < 6; i++) begin
      logic [27:0] a;
      a = 28'(i * 32'h0357BDF + 32'h8C4A21E);
      run_period(a, a ^ 28'h3C3C3C3, 1'(i % 2), 1'b1, 1, "R2 R3 R6");
    end

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule